// File: doc/BRIEF.md
# Forward Rectifier Gate Sequencer

This block produces the gate command for the forward-side synchronous rectifier of a single-switch forward converter. Two separate mechanisms decide the edges. Turn-on is driven by events. A slow flag reports that the rectifier drain has climbed well above ground, which means the transformer reset has begun, and this arms a precondition latch. The next fast flag reporting body-diode conduction then sets the gate latch. A body-diode event that arrives while the latch is not armed has no effect. Such an event occurs just after the primary switch opens.

Turn-off is predictive. Every falling edge of the PWM signal enters a 16-stage delay line clocked by `clk`. The stage that clears the gate is chosen by a 4-bit setting. A mismatch detector updates that setting once per PWM period. It watches for cycles in which the gate already reads low while the freewheeling drain still reads high. If any such cycle occurred, the turn-off came too early and the setting rises by one; otherwise it falls by one. The setting stays within the range 0 to 15. The analog comparators sit outside the block, and all flags arrive as digital levels sampled on `clk`.

`load` is the synchronous active-high initialisation input. It clears both latches, which turns the gate off, and sets the delay to zero.

Top module: `fwd_sr_gate`

## Requirements
- R1: A cycle with `load` high forces `gate_cmd` low on the next edge, disarms the precondition, sets the delay setting to 0 and forgets all PWM history.
- R2: `drain_hi` sampled high on an edge arms the precondition latch, unless `diode_on` is high on that same edge.
- R3: `diode_on` sampled high while the precondition latch is not armed leaves `gate_cmd` unchanged.
- R4: `diode_on` sampled high while the latch is armed sets `gate_cmd` high on that edge. It also disarms the latch, so a later `diode_on` with no new `drain_hi` does not turn the gate on.
- R5: Once high, `gate_cmd` stays high through any PWM rising edge and until a turn-off event.
- R6: Let t0 be the edge at which `pwm` is first sampled low after being sampled high, and k the delay setting. `gate_cmd` is cleared at edge t0+k, so it is low right after t0 when k=0.
- R7: The delay setting changes only on a PWM rising edge, which is the first sample of `pwm` high after a low sample. The setting rises by 1 if `gate_lo` and `fw_drain_hi` were both high on any edge of the period that is ending. That period runs from the previous rising edge, inclusive, to this one, exclusive. If no such edge occurred, the setting falls by 1.
- R8: The delay setting does not rise above 15.
- R9: The delay setting does not fall below 0.
- R10: When a turn-off event and a turn-on event fall on the same edge, `gate_cmd` ends low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| load | input | 1 | Synchronous active-high initialisation |
| pwm | input | 1 | Primary switch PWM control level |
| drain_hi | input | 1 | Slow flag: rectifier drain above the reset threshold |
| diode_on | input | 1 | Fast flag: rectifier body diode conducting |
| gate_lo | input | 1 | Rectifier gate voltage read as low |
| fw_drain_hi | input | 1 | Freewheeling rectifier drain read as high |
| gate_cmd | output | 1 | Gate command for the forward rectifier |

## Verification
The bench fires body-diode flags while the latch is not armed. A design that skips the arming gate would switch on at once. It also repeats a diode flag after a turn-on, where a latch that never disarms would switch the gate on a second time. The bench measures the turn-off delay while the mismatch detector drives the setting past both ends of its range; a wrapping counter would jump between 15 and 0. It also lines up a turn-on and a delayed PWM fall on the same edge, where the wrong priority would leave the gate on for a full period. A long stretch of random stimulus, interrupted by occasional `load` pulses, is compared on every edge against a model that keeps a history of PWM samples.

// File: rtl/fwd_sr_pkg.sv
package fwd_sr_pkg;

    // Number of stages in the turn-off delay line
    localparam int TAP_COUNT = 16;

    // Sampled comparator flags, bundled
    typedef struct packed {
        logic drain_hi;
        logic diode_on;
        logic gate_lo;
        logic fw_hi;
    } sense_t;

    // Per-period adjustment of the turn-off delay
    typedef enum logic [1:0] {
        ADJ_HOLD = 2'd0,
        ADJ_UP   = 2'd1,
        ADJ_DOWN = 2'd2
    } adj_e;

    function automatic adj_e pick_adj(input logic period_edge, input logic late_seen);
        if (!period_edge) return ADJ_HOLD;
        return late_seen ? ADJ_UP : ADJ_DOWN;
    endfunction

endpackage

// File: rtl/fwd_sr_arm.sv
module fwd_sr_arm
    import fwd_sr_pkg::*;
(
    input  logic   clk,
    input  logic   load,
    input  sense_t sense,
    output logic   armed,
    output logic   fire
);

    always_ff @(posedge clk) begin
        if (load)
            armed <= 1'b0;
        else if (sense.diode_on)
            armed <= 1'b0;
        else if (sense.drain_hi)
            armed <= 1'b1;
    end

    assign fire = sense.diode_on & armed;

    // R2: arming needs the slow high-drain flag one edge earlier
    assert_arm_source_R2: assert property (@(posedge clk) disable iff (load)
        $rose(armed) |-> $past(sense.drain_hi));

    // R4: a diode event always leaves the latch disarmed
    assert_diode_disarms_R4: assert property (@(posedge clk) disable iff (load)
        sense.diode_on |=> !armed);

endmodule

// File: rtl/fwd_sr_offline.sv
module fwd_sr_offline #(
    parameter int TAPS = 16,
    localparam int SW = $clog2(TAPS)
) (
    input  logic          clk,
    input  logic          load,
    input  logic          pwm,
    input  logic [SW-1:0] sel,
    output logic          kill,
    output logic          rise
);

    logic            pwm_q;
    logic [TAPS-2:0] fall_sr;
    logic            fall_now;
    logic [TAPS-1:0] stage;

    assign fall_now = pwm_q & ~pwm;
    assign rise     = ~pwm_q & pwm;
    assign stage    = {fall_sr, fall_now};
    assign kill     = stage[sel];

    always_ff @(posedge clk) begin
        if (load) begin
            pwm_q   <= 1'b0;
            fall_sr <= '0;
        end else begin
            pwm_q   <= pwm;
            fall_sr <= stage[TAPS-2:0];
        end
    end

endmodule

// File: rtl/fwd_sr_tuner.sv
module fwd_sr_tuner
    import fwd_sr_pkg::*;
#(
    parameter int TAPS = 16,
    localparam int SW = $clog2(TAPS),
    localparam logic [SW-1:0] TOP = SW'(TAPS - 1)
) (
    input  logic          clk,
    input  logic          load,
    input  logic          rise,
    input  logic          late,
    output logic [SW-1:0] sel
);

    logic late_seen;
    adj_e adj;

    assign adj = pick_adj(rise, late_seen);

    always_ff @(posedge clk) begin
        if (load) begin
            sel       <= '0;
            late_seen <= 1'b0;
        end else begin
            late_seen <= rise ? late : (late_seen | late);
            unique case (adj)
                ADJ_UP:   if (sel != TOP) sel <= sel + 1'b1;
                ADJ_DOWN: if (sel != '0)  sel <= sel - 1'b1;
                default:  ;
            endcase
        end
    end

    // R7: the setting moves only on a period edge
    assert_step_on_rise_R7: assert property (@(posedge clk) disable iff (load)
        !rise |=> $stable(sel));

    // R7: a late period moves the setting up by one
    assert_step_up_R7: assert property (@(posedge clk) disable iff (load)
        (rise && late_seen && sel != TOP) |=> sel == SW'($past(sel) + 1'b1));

    // R8: ceiling holds
    assert_ceiling_R8: assert property (@(posedge clk) disable iff (load)
        (rise && late_seen && sel == TOP) |=> sel == TOP);

    // R9: floor holds
    assert_floor_R9: assert property (@(posedge clk) disable iff (load)
        (rise && !late_seen && sel == '0) |=> sel == '0);

endmodule

// File: rtl/fwd_sr_gate.sv
module fwd_sr_gate
    import fwd_sr_pkg::*;
#(
    parameter int TAPS = TAP_COUNT,
    localparam int SW = $clog2(TAPS)
) (
    input  logic clk,
    input  logic load,
    input  logic pwm,
    input  logic drain_hi,
    input  logic diode_on,
    input  logic gate_lo,
    input  logic fw_drain_hi,
    output logic gate_cmd
);

    sense_t        sense;
    logic          armed;
    logic          fire;
    logic          kill;
    logic          rise;
    logic [SW-1:0] sel;
    logic          gate_q;

    assign sense = '{drain_hi: drain_hi, diode_on: diode_on,
                     gate_lo: gate_lo, fw_hi: fw_drain_hi};

    fwd_sr_arm u_arm (
        .clk   (clk),
        .load  (load),
        .sense (sense),
        .armed (armed),
        .fire  (fire)
    );

    fwd_sr_offline #(.TAPS(TAPS)) u_off (
        .clk  (clk),
        .load (load),
        .pwm  (pwm),
        .sel  (sel),
        .kill (kill),
        .rise (rise)
    );

    fwd_sr_tuner #(.TAPS(TAPS)) u_tune (
        .clk  (clk),
        .load (load),
        .rise (rise),
        .late (sense.gate_lo & sense.fw_hi),
        .sel  (sel)
    );

    // Gate latch: turn-off outranks turn-on
    always_ff @(posedge clk) begin
        if (load)
            gate_q <= 1'b0;
        else if (kill)
            gate_q <= 1'b0;
        else if (fire)
            gate_q <= 1'b1;
    end

    assign gate_cmd = gate_q;

    // R1: initialisation turns the gate off
    assert_load_off_R1: assert property (@(posedge clk)
        load |=> !gate_cmd);

    // R4: every turn-on comes from an armed diode event
    assert_turnon_cause_R4: assert property (@(posedge clk) disable iff (load)
        $rose(gate_cmd) |-> $past(fire));

    // R5: the gate holds until a turn-off event
    assert_hold_on_R5: assert property (@(posedge clk) disable iff (load)
        (gate_cmd && !kill) |=> gate_cmd);

    // R6 and R10: a turn-off event always wins
    assert_kill_wins_R10: assert property (@(posedge clk) disable iff (load)
        kill |=> !gate_cmd);

endmodule

// File: tb/sim_fwd_sr_gate.sv
module sim_fwd_sr_gate;

    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic load = 1'b1;
    logic pwm = 1'b0, drain_hi = 1'b0, diode_on = 1'b0, gate_lo = 1'b0, fw_drain_hi = 1'b0;
    logic gate_cmd;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string tag = "R1 init";

    // behavioural reference state
    bit m_gate = 0, m_arm = 0, m_late = 0;
    int m_sel = 0;
    bit hist[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    fwd_sr_gate u0 (
        .clk(clk), .load(load), .pwm(pwm), .drain_hi(drain_hi),
        .diode_on(diode_on), .gate_lo(gate_lo), .fw_drain_hi(fw_drain_hi),
        .gate_cmd(gate_cmd)
    );

    function automatic bit ago(int j);
        int n = hist.size();
        if (n - 1 - j < 0) return 1'b0;
        return hist[n - 1 - j];
    endfunction

    task automatic model_edge(bit p, bit h, bit b, bit gl, bit fh, bit ld);
        bit off_ev, rise_ev;
        if (ld) begin
            m_gate = 0; m_arm = 0; m_sel = 0; m_late = 0;
            hist.delete();
            return;
        end
        rise_ev = !ago(0) && p;
        hist.push_back(p);
        if (hist.size() > 40) void'(hist.pop_front());
        off_ev = ago(m_sel + 1) && !ago(m_sel);
        if (off_ev)          m_gate = 0;
        else if (b && m_arm) m_gate = 1;
        if (b)      m_arm = 0;
        else if (h) m_arm = 1;
        if (rise_ev) begin
            if (m_late) m_sel = (m_sel < 15) ? m_sel + 1 : 15;
            else        m_sel = (m_sel > 0) ? m_sel - 1 : 0;
            m_late = gl && fh;
        end else begin
            m_late = m_late || (gl && fh);
        end
    endtask

    task automatic step(bit p, bit h, bit b, bit gl, bit fh, bit ld);
        pwm = p; drain_hi = h; diode_on = b; gate_lo = gl; fw_drain_hi = fh; load = ld;
        model_edge(p, h, b, gl, fh, ld);
        @(negedge clk);
        n_chk++;
        if (gate_cmd !== m_gate) begin
            n_bad++;
            $display("FAIL %s: gate_cmd=%0b expected %0b at %0t", tag, gate_cmd, m_gate, $time);
        end
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // drive PWM low and count edges until the gate drops
    task automatic fall_measure(output int k);
        step(0, 0, 0, 0, 0, 0);
        k = 0;
        while (gate_cmd && k < 40) begin
            step(0, 0, 0, 0, 0, 0);
            k++;
        end
    endtask

    // one full period: arm, fire, rise, optional late sample, fall
    task automatic period(bit late, output int k);
        step(0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, late, late, 0);
        step(1, 0, 0, 0, 0, 0);
        fall_measure(k);
        repeat (3) step(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        int k, exp_sel;
        bit prev_late;

        // R1: initial state
        repeat (3) step(0, 0, 0, 0, 0, 1);
        chk("R1 gate low after load", gate_cmd, 0);

        // R3: diode events with nothing armed
        tag = "R3 unarmed diode";
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R3 gate stays low", gate_cmd, 0);

        // R2 and R4: arm then fire
        tag = "R2 R4 arm and fire";
        step(0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R2 no turn-on from arming alone", gate_cmd, 0);
        step(0, 0, 1, 0, 0, 0);
        chk("R4 gate on after armed diode", gate_cmd, 1);

        // R5: survives the PWM rising edge
        tag = "R5 hold";
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        chk("R5 gate held across rise", gate_cmd, 1);

        // R6: delay zero
        tag = "R6 turn-off";
        fall_measure(k);
        chk("R6 delay at setting 0", k, 0);

        // R4: latch was disarmed by the firing event
        tag = "R4 disarmed";
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R4 second diode ignored", gate_cmd, 0);

        // R7 R8 R9: adaptive delay
        tag = "R7 tuning";
        step(0, 0, 0, 0, 0, 1);
        exp_sel = 0; prev_late = 0;
        for (int i = 0; i < 3; i++) begin
            exp_sel = prev_late ? exp_sel + 1 : exp_sel - 1;
            if (exp_sel < 0) exp_sel = 0;
            period(0, k);
            prev_late = 0;
            chk("R9 floor at 0", k, exp_sel);
        end
        for (int i = 0; i < 19; i++) begin
            exp_sel = prev_late ? exp_sel + 1 : exp_sel - 1;
            if (exp_sel > 15) exp_sel = 15;
            if (exp_sel < 0) exp_sel = 0;
            period(1, k);
            prev_late = 1;
            chk("R7 delay follows late periods", k, exp_sel);
        end
        period(1, k);
        chk("R8 ceiling at 15", k, 15);
        prev_late = 1;
        for (int i = 0; i < 18; i++) begin
            exp_sel = prev_late ? exp_sel + 1 : exp_sel - 1;
            if (exp_sel > 15) exp_sel = 15;
            if (exp_sel < 0) exp_sel = 0;
            period(0, k);
            prev_late = 0;
            chk("R7 delay falls on clean periods", k, exp_sel);
        end
        chk("R9 back at floor", k, 0);

        // R10: turn-off and turn-on on the same edge (setting is 0)
        tag = "R10 priority";
        step(0, 1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        chk("R10 clear beats set", gate_cmd, 0);

        // R1: load in mid-operation
        tag = "R1 mid load";
        step(0, 1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        chk("R4 on before load", gate_cmd, 1);
        step(0, 1, 0, 0, 0, 1);
        chk("R1 load drops gate", gate_cmd, 0);
        step(0, 0, 1, 0, 0, 0);
        chk("R1 load disarmed latch", gate_cmd, 0);

        // random stress against the model
        tag = "R6 R7 random";
        for (int i = 0; i < 4000; i++) begin
            bit p;
            p = ($urandom % 8 == 0) ? !pwm : pwm;
            step(p, $urandom % 6 == 0, $urandom % 5 == 0,
                 $urandom % 3 == 0, $urandom % 3 == 0, $urandom % 700 == 0);
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule